// File: doc/BRIEF.md
# Timer Control Register with Cross-Domain Enable and Reset

This block is the main control register of a timer/counter. It is written and read on a bus-clock register port and holds the counter width selection, a run bit, a self-clearing soft-reset bit, and two per-channel capture bits (capture versus compare, and pin versus event trigger). The run bit and the soft reset must reach a counter that runs on an unrelated core clock. Each travels through its own toggle handshake. A two-bit busy status shows which transfer is still open.

A written run value reads back on the next bus cycle. The core-domain run state follows it only after the handshake completes, and the busy flag stays up until then. A soft-reset write overrides every other field in the same word. It clears the register to its reset values and stops the counter. It leaves the separate debug register untouched and holds the reset bit at 1 until the core domain has seen the reset. Run writes that arrive while a transfer is open are queued, so the core always ends on the last value written.

Top module: `tcs_ctrl_regs`

## Requirements
- R1: After bus and core reset, `ctrl_rd` is 0, `sync_busy` is 0, `core_en` is 0, the capture and mode outputs are 0 and `dbg_q` is 0.
- R2: A write accepted at a bus edge is visible on `ctrl_rd` at the next bus cycle. Run is bit 1, mode is bits 3:2, capture enables are bits 17:16 and capture-pin selects are bits 21:20. All other bits read 0.
- R3: A write with bit 0 = 0 outside a soft reset sets `sync_busy[1]` on the next bus cycle. That flag clears only after `core_en` equals the written run value.
- R4: For any series of run writes, including writes made while `sync_busy[1]` is set, `core_en` equals the last written run value once `sync_busy` returns to 0.
- R5: A write with bit 0 = 1 clears run, mode and both capture fields, ignores every other bit of that word, and drives `core_en` to 0. It also pulses `core_reset` once in the core domain.
- R6: During a soft reset, `ctrl_rd[0]` and `sync_busy[0]` are both 1, and they fall to 0 in the same bus cycle.
- R7: A write that arrives while `sync_busy[0]` is 1 is discarded, so all fields keep their values.
- R8: The debug register `dbg_q` is loaded only through `dbg_wr_en`, and a soft reset does not change it.
- R9: `cap_en` and `cap_pin` follow their register bits on the next bus cycle with no handshake. 1 means capture, or pin trigger; 0 means compare, or event trigger.
- R10: Mode code 2 means 32-bit counting and code 3 is reserved. A write carrying code 3 leaves the mode field unchanged, while its other fields still update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register interface clock |
| bus_rst_n | input | 1 | Synchronous active-low reset, bus domain |
| core_clk | input | 1 | Counter clock |
| core_rst_n | input | 1 | Synchronous active-low reset, core domain |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 32 | Control register write data |
| ctrl_rd | output | 32 | Control register read value |
| sync_busy | output | 2 | Bit 0 soft reset in transfer, bit 1 run value in transfer |
| dbg_wr_en | input | 1 | Debug register write strobe |
| dbg_wr_data | input | DBG_W | Debug register write data |
| dbg_q | output | DBG_W | Debug register value |
| mode_q | output | 2 | Counter width selection |
| cap_en | output | N_CH | Per-channel capture enable |
| cap_pin | output | N_CH | Per-channel capture trigger from pin |
| core_en | output | 1 | Run state in the core domain |
| core_reset | output | 1 | One core-cycle soft-reset pulse |

## Verification
Most internal faults here show at the ports within one round trip of a handshake, which is a few cycles of each clock. A lost or doubled toggle leaves `sync_busy` stuck high, or lowers it while `core_en` still differs from the last run value. A queued write that is dropped shows up as a final `core_en` that disagrees with `ctrl_rd[1]` once the bus is idle. Faults in the bus-domain field updates show on `ctrl_rd` on the very next cycle. These include a soft reset that leaks other bits, a write that slips through during reset, or an accepted reserved mode.

// File: rtl/tcs_pkg.sv
// Package: field positions and widths of the timer control word.
// Assumes a 32-bit register data path.
package tcs_pkg;
    localparam int REG_W      = 32;
    localparam int BIT_SWRST  = 0;
    localparam int BIT_RUN    = 1;
    localparam int MODE_LSB   = 2;
    localparam int MODE_W     = 2;
    localparam int CAPEN_LSB  = 16;
    localparam int CAPPIN_LSB = 20;

    typedef enum logic [MODE_W-1:0] {
        MODE_W16  = 2'd0,
        MODE_W8   = 2'd1,
        MODE_W32  = 2'd2,
        MODE_RSVD = 2'd3
    } tcs_mode_e;
endpackage

// File: rtl/tcs_sync.sv
// Multi-flop level synchronizer.
// Assumes STAGES >= 2 and a quasi-static input (a toggle level).
module tcs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] ff;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) ff <= '0;
        else        ff <= {ff[STAGES-2:0], d};
    end

    assign q = ff[STAGES-1];
endmodule

// File: rtl/tcs_hshake.sv
// Toggle request/acknowledge handshake from the bus to the core domain.
// A launch flips the request. The core side detects the change, emits one
// core-cycle pulse and returns the level as the acknowledge. The bus side
// is idle once the synchronized acknowledge equals the request.
// Assumes launch is raised only while idle.
module tcs_hshake #(
    parameter int SYNC_STAGES = 2
) (
    input  logic bus_clk,
    input  logic bus_rst_n,
    input  logic core_clk,
    input  logic core_rst_n,
    input  logic launch,
    output logic idle,
    output logic core_pulse
);
    logic req_tgl, req_core, ack_tgl, ack_bus;

    // Flip the request level on each launch.
    always_ff @(posedge bus_clk) begin
        if (!bus_rst_n)  req_tgl <= 1'b0;
        else if (launch) req_tgl <= ~req_tgl;
    end

    tcs_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk(core_clk), .rst_n(core_rst_n), .d(req_tgl), .q(req_core)
    );

    // Echo the synchronized request as the acknowledge level.
    always_ff @(posedge core_clk) begin
        if (!core_rst_n) ack_tgl <= 1'b0;
        else             ack_tgl <= req_core;
    end

    assign core_pulse = req_core ^ ack_tgl;

    tcs_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk(bus_clk), .rst_n(bus_rst_n), .d(ack_tgl), .q(ack_bus)
    );

    assign idle = (req_tgl == ack_bus);

    AST_LAUNCH_WHEN_IDLE: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        launch |-> idle); // R4
endmodule

// File: rtl/tcs_core.sv
// Core-domain run state. A soft-reset pulse forces it off. A run pulse
// loads the value held stable on the bus side for the whole transfer.
// Assumes the two pulses never coincide (the bus side serializes them).
module tcs_core (
    input  logic core_clk,
    input  logic core_rst_n,
    input  logic run_pulse,
    input  logic rst_pulse,
    input  logic run_value,
    output logic core_en
);
    // Update the run state from whichever transfer completed.
    always_ff @(posedge core_clk) begin
        if (!core_rst_n)    core_en <= 1'b0;
        else if (rst_pulse) core_en <= 1'b0;
        else if (run_pulse) core_en <= run_value;
    end

    AST_ONE_TRANSFER: assert property (@(posedge core_clk) disable iff (!core_rst_n)
        $onehot0({run_pulse, rst_pulse})); // R4
endmodule

// File: rtl/tcs_ctrl_regs.sv
// Timer control register. Bus-domain fields read back at once. Run and
// soft reset cross to the core clock through two serialized handshakes.
// A soft reset clears all fields except the debug register. Assumes the
// core counter samples mode only while it is stopped.
module tcs_ctrl_regs
    import tcs_pkg::*;
#(
    parameter int N_CH        = 2,
    parameter int DBG_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              bus_clk,
    input  logic              bus_rst_n,
    input  logic              core_clk,
    input  logic              core_rst_n,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    output logic [REG_W-1:0]  ctrl_rd,
    output logic [1:0]        sync_busy,
    input  logic              dbg_wr_en,
    input  logic [DBG_W-1:0]  dbg_wr_data,
    output logic [DBG_W-1:0]  dbg_q,
    output logic [MODE_W-1:0] mode_q,
    output logic [N_CH-1:0]   cap_en,
    output logic [N_CH-1:0]   cap_pin,
    output logic              core_en,
    output logic              core_reset
);
    logic run_q, run_sent, run_dirty, rst_pend;
    logic run_idle, rst_idle, run_launch, rst_launch, run_pulse;
    logic rst_busy, wr_ok, rst_req;
    logic [MODE_W-1:0] mode_wr;

    assign rst_busy   = rst_pend | ~rst_idle;
    assign wr_ok      = wr_en & ~rst_busy;
    assign rst_req    = wr_ok & wr_data[BIT_SWRST];
    assign mode_wr    = wr_data[MODE_LSB +: MODE_W];
    assign run_launch = run_dirty & run_idle & ~rst_busy;
    assign rst_launch = rst_pend & run_idle;

    // Bus-domain fields, queued run transfer and pending soft reset.
    always_ff @(posedge bus_clk) begin
        if (!bus_rst_n) begin
            run_q     <= 1'b0;
            mode_q    <= '0;
            cap_en    <= '0;
            cap_pin   <= '0;
            run_dirty <= 1'b0;
            rst_pend  <= 1'b0;
        end else if (rst_req) begin
            run_q     <= 1'b0;
            mode_q    <= '0;
            cap_en    <= '0;
            cap_pin   <= '0;
            run_dirty <= 1'b0;
            rst_pend  <= 1'b1;
        end else begin
            if (rst_launch) rst_pend  <= 1'b0;
            if (run_launch) run_dirty <= 1'b0;
            if (wr_ok) begin
                run_q     <= wr_data[BIT_RUN];
                cap_en    <= wr_data[CAPEN_LSB +: N_CH];
                cap_pin   <= wr_data[CAPPIN_LSB +: N_CH];
                run_dirty <= 1'b1;
                if (mode_wr != MODE_RSVD) mode_q <= mode_wr;
            end
        end
    end

    // Value carried by the run transfer, frozen while it is in flight.
    always_ff @(posedge bus_clk) begin
        if (!bus_rst_n)      run_sent <= 1'b0;
        else if (run_launch) run_sent <= run_q;
    end

    // Debug register, touched only by its own strobe and the bus reset.
    always_ff @(posedge bus_clk) begin
        if (!bus_rst_n)     dbg_q <= '0;
        else if (dbg_wr_en) dbg_q <= dbg_wr_data;
    end

    tcs_hshake #(.SYNC_STAGES(SYNC_STAGES)) u_run_hs (
        .bus_clk(bus_clk), .bus_rst_n(bus_rst_n),
        .core_clk(core_clk), .core_rst_n(core_rst_n),
        .launch(run_launch), .idle(run_idle), .core_pulse(run_pulse)
    );

    tcs_hshake #(.SYNC_STAGES(SYNC_STAGES)) u_rst_hs (
        .bus_clk(bus_clk), .bus_rst_n(bus_rst_n),
        .core_clk(core_clk), .core_rst_n(core_rst_n),
        .launch(rst_launch), .idle(rst_idle), .core_pulse(core_reset)
    );

    tcs_core u_core (
        .core_clk(core_clk), .core_rst_n(core_rst_n),
        .run_pulse(run_pulse), .rst_pulse(core_reset),
        .run_value(run_sent), .core_en(core_en)
    );

    // Assemble the read word; unused bits read as zero.
    always_comb begin
        ctrl_rd                          = '0;
        ctrl_rd[BIT_SWRST]               = rst_busy;
        ctrl_rd[BIT_RUN]                 = run_q;
        ctrl_rd[MODE_LSB +: MODE_W]      = mode_q;
        ctrl_rd[CAPEN_LSB +: N_CH]       = cap_en;
        ctrl_rd[CAPPIN_LSB +: N_CH]      = cap_pin;
    end

    assign sync_busy = {run_dirty | ~run_idle, rst_busy};

    AST_RUN_BUSY_SET: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        (wr_en && !sync_busy[0] && !wr_data[BIT_SWRST]) |=> sync_busy[1]); // R3
    AST_SWRST_CLEARS: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        (wr_en && !sync_busy[0] && wr_data[BIT_SWRST]) |=>
        (run_q == 1'b0 && mode_q == '0 && cap_en == '0 && cap_pin == '0 && sync_busy[0])); // R5
    AST_WRITE_BLOCKED: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        (wr_en && sync_busy[0]) |=> $stable({run_q, mode_q, cap_en, cap_pin})); // R7
    AST_DBG_HELD: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        !dbg_wr_en |=> $stable(dbg_q)); // R8
    AST_NO_RESERVED_MODE: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        mode_q != MODE_RSVD); // R10
endmodule

// File: tb/tcs_ctrl_regs_bench.sv
module tcs_ctrl_regs_bench;
    localparam int N_CH  = 2;
    localparam int DBG_W = 8;

    logic bus_clk = 1'b0, core_clk = 1'b0;
    logic bus_rst_n = 1'b0, core_rst_n = 1'b0;
    logic wr_en = 1'b0, dbg_wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [DBG_W-1:0] dbg_wr_data = '0;
    logic [31:0] ctrl_rd;
    logic [1:0] sync_busy, mode_q;
    logic [DBG_W-1:0] dbg_q;
    logic [N_CH-1:0] cap_en, cap_pin;
    logic core_en, core_reset;

    int checks = 0, errors = 0, cycles = 0, rst_pulses = 0;
    logic m_run = 0;
    logic [1:0] m_mode = 0, m_capen = 0, m_cappin = 0;

    always #2 bus_clk = ~bus_clk;
    always #3.7 core_clk = ~core_clk;

    tcs_ctrl_regs u_tcs_ctrl_regs (
        .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .core_clk(core_clk), .core_rst_n(core_rst_n),
        .wr_en(wr_en), .wr_data(wr_data), .ctrl_rd(ctrl_rd), .sync_busy(sync_busy),
        .dbg_wr_en(dbg_wr_en), .dbg_wr_data(dbg_wr_data), .dbg_q(dbg_q),
        .mode_q(mode_q), .cap_en(cap_en), .cap_pin(cap_pin),
        .core_en(core_en), .core_reset(core_reset)
    );

    always @(posedge core_clk) if (core_rst_n && core_reset) rst_pulses++;

    always @(posedge bus_clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic logic [31:0] exp_word(input logic sw);
        return {10'b0, m_cappin, 2'b0, m_capen, 12'b0, m_mode, m_run, sw};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Normal write (bit 0 must be clear, no reset in progress); model and check.
    task automatic do_write(input logic [31:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge bus_clk);
        wr_en = 1'b0;
        m_run = d[1];
        if (d[3:2] != 2'd3) m_mode = d[3:2];
        m_capen = d[17:16]; m_cappin = d[21:20];
        chk(ctrl_rd == exp_word(1'b0), "R2/R10 readback", ctrl_rd, exp_word(1'b0));
        chk({cap_en, cap_pin, mode_q} == {m_capen, m_cappin, m_mode}, "R9 capture outputs",
            {26'b0, cap_en, cap_pin, mode_q}, {26'b0, m_capen, m_cappin, m_mode});
        chk(sync_busy[1] == 1'b1, "R3 busy set", {30'b0, sync_busy}, 32'd2);
    endtask

    // Wait for both transfers to finish and check the core state.
    task automatic wait_idle(input string req);
        bit split = 0;
        for (int i = 0; i < 300 && sync_busy != 2'b00; i++) begin
            @(negedge bus_clk);
            if (ctrl_rd[0] != sync_busy[0]) split = 1;
        end
        chk(!split, "R6 reset bit and busy together", {31'b0, split}, 32'd0);
        chk(sync_busy == 2'b00, req, {30'b0, sync_busy}, 32'd0);
        chk(core_en == m_run, "R4 core run matches last write", {31'b0, core_en}, {31'b0, m_run});
    endtask

    task automatic do_swrst(input logic [31:0] d);
        int p0 = rst_pulses;
        wr_en = 1'b1; wr_data = d | 32'd1;
        @(negedge bus_clk);
        wr_en = 1'b0;
        m_run = 0; m_mode = 0; m_capen = 0; m_cappin = 0;
        chk(ctrl_rd == 32'd1, "R5 reset discards word", ctrl_rd, 32'd1);
        chk(sync_busy[0] == 1'b1, "R6 reset busy set", {30'b0, sync_busy}, 32'd1);
        wr_en = 1'b1; wr_data = 32'h0033_000E;
        @(negedge bus_clk);
        wr_en = 1'b0;
        chk(ctrl_rd == 32'd1, "R7 write during reset dropped", ctrl_rd, 32'd1);
        wait_idle("R6 reset completes");
        chk(ctrl_rd == 32'd0, "R6 reset bit cleared", ctrl_rd, 32'd0);
        repeat (3) @(negedge bus_clk);
        chk(rst_pulses == p0 + 1, "R5 one core reset pulse", rst_pulses, p0 + 1);
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (4) @(negedge bus_clk);
        bus_rst_n = 1'b1; core_rst_n = 1'b1;
        @(negedge bus_clk);
        chk(ctrl_rd == 0 && sync_busy == 0 && core_en == 0 && dbg_q == 0 &&
            cap_en == 0 && cap_pin == 0 && mode_q == 0, "R1 reset state",
            {ctrl_rd[31:4], sync_busy, core_en, |dbg_q}, 32'd0);

        dbg_wr_en = 1'b1; dbg_wr_data = 8'hA5;
        @(negedge bus_clk);
        dbg_wr_en = 1'b0;

        // Directed: enable, then 32-bit mode, then reserved mode keeps 32-bit.
        do_write(32'h0000_000A);
        wait_idle("R3 busy clears after run");
        do_write(32'h0021_000E);
        chk(mode_q == 2'd3 ? 0 : 1, "R10 reserved code rejected", {30'b0, mode_q}, {30'b0, m_mode});
        // Back-to-back run toggles while busy.
        do_write(32'h0000_0000);
        do_write(32'h0000_0002);
        do_write(32'h0000_0000);
        wait_idle("R4 queued writes settle");

        do_swrst(32'hFFFF_FFFF);
        chk(dbg_q == 8'hA5, "R8 debug kept over reset", {24'b0, dbg_q}, 32'hA5);
        chk(core_en == 1'b0, "R5 core stopped", {31'b0, core_en}, 32'd0);

        // Reset while a run transfer is in flight.
        do_write(32'h0000_0002);
        do_swrst(32'h0000_0002);

        // Random writes with short gaps.
        for (int i = 0; i < 60; i++) begin
            logic [31:0] d = $urandom();
            d[0] = 1'b0;
            do_write(d);
            repeat ($urandom_range(0, 3)) @(negedge bus_clk);
            if (i % 10 == 9) wait_idle("R4 random settle");
            if (i % 20 == 19) do_swrst($urandom());
        end
        wait_idle("R4 final settle");
        chk(dbg_q == 8'hA5, "R8 debug final", {24'b0, dbg_q}, 32'hA5);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule